// File: doc/BRIEF.md
# Set-Associative Translation Buffer with Access-Rights Check

This block keeps recently used page translations so that a memory access can get its physical frame without a page-table read. Pages are 4 KB, so the low twelve address bits pass straight through. The 20-bit virtual page number is split into two parts. Its five low bits pick one of 32 sets. Its upper fifteen bits are kept as the tag, and each of the four ways in the chosen set compares that tag with the request.

A lookup returns its result one cycle after the request. The result is a hit with the physical address, a miss, or a rights fault. A rights fault means that an entry matched but the kind of access (read, write or execute) is not allowed by that entry's rights. A page walker outside this block loads new translations through the fill port after a miss. A single flush input empties the whole array when the address space changes. A snoop port removes the one entry for a page that is being swapped out. When a fill needs a victim, it uses a three-bit tree pseudo-LRU per set.

Top module: `tlb_prot`

## Requirements
- R1: On a hit, `rsp_paddr` equals the stored 20-bit frame number joined above bits 11:0 of the request address, and those low bits are not translated.
- R2: `rsp_valid` rises exactly one cycle after `lk_valid` and only then. The result for a request made in cycle t appears in cycle t+1. When `rsp_valid` is 0, `rsp_hit`, `rsp_fault` and `rsp_paddr` are all 0.
- R3: Rights codes are 0 read-only, 1 read/write, 2 execute-only and 3 no access. Access kinds are 0 read, 1 write, 2 execute and 3 never allowed. Read-only allows only reads. Read/write allows reads and writes. Execute-only allows only execution.
- R4: A lookup whose tag matches no valid way in its set answers with hit 0, fault 0 and address 0.
- R5: A lookup that matches a valid entry whose rights forbid the access answers with fault 1, hit 0 and address 0.
- R6: A fill goes to set `fill_vpn[4:0]`. If that page is already present, the fill overwrites the same way. Otherwise it takes the lowest-numbered invalid way.
- R7: After a flush, every earlier translation misses.
- R8: A snoop invalidate removes the entry of the named page if one is present, and leaves every other entry usable.
- R9: Each set has a pseudo-LRU tree of three bits, all 0 after reset. Bit 0 set to 0 points the victim to ways 0–1, and set to 1 points it to ways 2–3. Bit 1 picks between way 0 and way 1, and bit 2 picks between way 2 and way 3. A permitted hit or a fill in a way turns the bits on its path away from that way. When all four ways are valid, a fill replaces the way the tree points to.
- R10: When a fill and a flush occur in the same cycle, the flush wins and the filled page is absent.
- R11: A lookup sees the array as it was before any fill made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Permitted translation found |
| rsp_fault | output | 1 | Entry found but access forbidden |
| rsp_paddr | output | 32 | Physical address on a hit, else 0 |
| fill_valid | input | 1 | Load a translation |
| fill_vpn | input | 20 | Virtual page number to load |
| fill_pfn | input | 20 | Physical frame number to load |
| fill_rights | input | 2 | Rights code of the loaded entry |
| flush | input | 1 | Invalidate every entry |
| snoop_valid | input | 1 | Invalidate one page |
| snoop_vpn | input | 20 | Page to invalidate |

## Verification
Some rules are checked by assertions on every cycle:
- the one-cycle response timing;
- the quiet outputs when there is no response;
- that hit and fault are never both set;
- that the offset passes through on a hit;
- that no lookup made just after a flush finds anything;
- that no lookup of a page snooped out in the cycle before finds it (unless a fill restored the page in that same cycle).

Other rules depend on what the array holds, so only the bench scenarios can show them: the full rights table, overwrite on refill, lowest-invalid-way choice, the pseudo-LRU victim order after hits, and flush taking precedence over a same-cycle fill.

// File: rtl/tlb_prot.sv
module tlb_prot #(
  parameter int VA_W    = 32,
  parameter int PG_BITS = 12,
  parameter int PFN_W   = 20,
  parameter int SETS    = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       lk_valid,
  input  logic [VA_W-1:0]            lk_vaddr,
  input  logic [1:0]                 lk_kind,
  output logic                       rsp_valid,
  output logic                       rsp_hit,
  output logic                       rsp_fault,
  output logic [PFN_W+PG_BITS-1:0]   rsp_paddr,
  input  logic                       fill_valid,
  input  logic [VA_W-PG_BITS-1:0]    fill_vpn,
  input  logic [PFN_W-1:0]           fill_pfn,
  input  logic [1:0]                 fill_rights,
  input  logic                       flush,
  input  logic                       snoop_valid,
  input  logic [VA_W-PG_BITS-1:0]    snoop_vpn
);
  localparam int WAYS  = 4;
  localparam int VPN_W = VA_W - PG_BITS;
  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - SET_W;

  logic [WAYS-1:0]  vld  [SETS];
  logic [2:0]       plru [SETS];
  logic [TAG_W-1:0] tg   [SETS][WAYS];
  logic [PFN_W-1:0] frm  [SETS][WAYS];
  logic [1:0]       acc  [SETS][WAYS];

  function automatic logic perm_ok(input logic [1:0] r, input logic [1:0] k);
    case (r)
      2'd0:    perm_ok = (k == 2'd0);
      2'd1:    perm_ok = (k == 2'd0) || (k == 2'd1);
      2'd2:    perm_ok = (k == 2'd2);
      default: perm_ok = 1'b0;
    endcase
  endfunction

  function automatic logic [2:0] touch(input logic [2:0] p, input logic [1:0] w);
    touch    = p;
    touch[0] = ~w[1];
    if (w[1]) touch[2] = ~w[0];
    else      touch[1] = ~w[0];
  endfunction

  logic [SET_W-1:0] lk_set, f_set, s_set;
  logic [TAG_W-1:0] lk_tag, f_tag, s_tag;
  assign lk_set = lk_vaddr[PG_BITS +: SET_W];
  assign lk_tag = lk_vaddr[VA_W-1 -: TAG_W];
  assign f_set  = fill_vpn[SET_W-1:0];
  assign f_tag  = fill_vpn[VPN_W-1 -: TAG_W];
  assign s_set  = snoop_vpn[SET_W-1:0];
  assign s_tag  = snoop_vpn[VPN_W-1 -: TAG_W];

  logic [WAYS-1:0] lk_match, f_match, s_match;
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign lk_match[w] = vld[lk_set][w] && (tg[lk_set][w] == lk_tag);
    assign f_match[w]  = vld[f_set][w]  && (tg[f_set][w]  == f_tag);
    assign s_match[w]  = vld[s_set][w]  && (tg[s_set][w]  == s_tag);
  end

  logic [PFN_W-1:0] sel_pfn;
  logic [1:0]       sel_acc, lk_way;
  always_comb begin
    sel_pfn = '0;
    sel_acc = '0;
    lk_way  = '0;
    for (int w = 0; w < WAYS; w++)
      if (lk_match[w]) begin
        sel_pfn |= frm[lk_set][w];
        sel_acc |= acc[lk_set][w];
        lk_way  |= 2'(w);
      end
  end

  logic lk_any, lk_ok;
  assign lk_any = |lk_match;
  assign lk_ok  = lk_any && perm_ok(sel_acc, lk_kind);

  logic [WAYS-1:0] f_free;
  logic [1:0]      f_way;
  assign f_free = ~vld[f_set];
  always_comb begin
    f_way = plru[f_set][0] ? {1'b1, plru[f_set][2]} : {1'b0, plru[f_set][1]};
    if (|f_match) begin
      for (int w = 0; w < WAYS; w++)
        if (f_match[w]) f_way = 2'(w);
    end else if (|f_free) begin
      for (int w = WAYS - 1; w >= 0; w--)
        if (f_free[w]) f_way = 2'(w);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld[s]  <= '0;
        plru[s] <= '0;
      end
    end else if (flush) begin
      for (int s = 0; s < SETS; s++) begin
        vld[s]  <= '0;
        plru[s] <= '0;
      end
    end else begin
      if (lk_valid && lk_ok)
        plru[lk_set] <= touch(plru[lk_set], lk_way);
      if (snoop_valid)
        for (int w = 0; w < WAYS; w++)
          if (s_match[w]) vld[s_set][w] <= 1'b0;
      if (fill_valid) begin
        vld[f_set][f_way] <= 1'b1;
        plru[f_set]       <= touch(plru[f_set], f_way);
      end
    end
  end

  always_ff @(posedge clk)
    if (fill_valid && !flush) begin
      tg[f_set][f_way]  <= f_tag;
      frm[f_set][f_way] <= fill_pfn;
      acc[f_set][f_way] <= fill_rights;
    end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && lk_ok;
      rsp_fault <= lk_valid && lk_any && !lk_ok;
      rsp_paddr <= (lk_valid && lk_ok) ? {sel_pfn, lk_vaddr[PG_BITS-1:0]} : '0;
    end
  end
endmodule

// File: rtl/tlb_prot_chk.sv
module tlb_prot_chk #(
  parameter int VA_W    = 32,
  parameter int PG_BITS = 12,
  parameter int PFN_W   = 20
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     lk_valid,
  input logic [VA_W-1:0]          lk_vaddr,
  input logic                     rsp_valid,
  input logic                     rsp_hit,
  input logic                     rsp_fault,
  input logic [PFN_W+PG_BITS-1:0] rsp_paddr,
  input logic                     fill_valid,
  input logic [VA_W-PG_BITS-1:0]  fill_vpn,
  input logic                     flush,
  input logic                     snoop_valid,
  input logic [VA_W-PG_BITS-1:0]  snoop_vpn
);
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid); // R2
  AST_RSP_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid); // R2
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_hit && !rsp_fault && rsp_paddr == '0)); // R2
  AST_HIT_XOR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_fault)); // R5
  AST_OFFSET_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_paddr[PG_BITS-1:0] == $past(lk_vaddr[PG_BITS-1:0])); // R1
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flush) && lk_valid) |=> (!rsp_hit && !rsp_fault)); // R7
  AST_SNOOP_REMOVES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(snoop_valid) && lk_valid && lk_vaddr[VA_W-1:PG_BITS] == $past(snoop_vpn)
     && !($past(fill_valid) && $past(fill_vpn) == $past(snoop_vpn)))
    |=> (!rsp_hit && !rsp_fault)); // R8
endmodule

bind tlb_prot tlb_prot_chk #(.VA_W(VA_W), .PG_BITS(PG_BITS), .PFN_W(PFN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
  .fill_valid(fill_valid), .fill_vpn(fill_vpn), .flush(flush),
  .snoop_valid(snoop_valid), .snoop_vpn(snoop_vpn));

// File: tb/sim_tlb_prot.sv
module sim_tlb_prot;
  logic        clk = 0, rst_n = 0;
  logic        lk_valid = 0;
  logic [31:0] lk_vaddr = '0;
  logic [1:0]  lk_kind = '0;
  logic        rsp_valid, rsp_hit, rsp_fault;
  logic [31:0] rsp_paddr;
  logic        fill_valid = 0;
  logic [19:0] fill_vpn = '0, fill_pfn = '0;
  logic [1:0]  fill_rights = '0;
  logic        flush = 0, snoop_valid = 0;
  logic [19:0] snoop_vpn = '0;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  tlb_prot u0 (.*);

  function automatic [19:0] vpn(input [14:0] t, input [4:0] s);
    return {t, s};
  endfunction

  task automatic judge(input string req, input logic ev, eh, ef, input [31:0] ep);
    total++;
    if (rsp_valid !== ev || rsp_hit !== eh || rsp_fault !== ef || rsp_paddr !== ep) begin
      bad++;
      $display("FAIL %s: got v=%b h=%b f=%b pa=%h, expected v=%b h=%b f=%b pa=%h",
               req, rsp_valid, rsp_hit, rsp_fault, rsp_paddr, ev, eh, ef, ep);
    end
  endtask

  task automatic look(input [19:0] p, input [11:0] off, input [1:0] k, input string req,
                      input logic eh, ef, input [31:0] ep);
    @(negedge clk); lk_valid = 1; lk_vaddr = {p, off}; lk_kind = k;
    @(negedge clk); lk_valid = 0;
    judge(req, 1'b1, eh, ef, ep);
  endtask

  task automatic fill(input [19:0] p, input [19:0] f, input [1:0] r);
    @(negedge clk); fill_valid = 1; fill_vpn = p; fill_pfn = f; fill_rights = r;
    @(negedge clk); fill_valid = 0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
  endtask

  task automatic snoop(input [19:0] p);
    @(negedge clk); snoop_valid = 1; snoop_vpn = p;
    @(negedge clk); snoop_valid = 0;
  endtask

  task automatic t_reset();
    judge("R2 reset outputs", 0, 0, 0, 0);
    look(vpn(15'd9, 5'd1), 12'h0, 2'd0, "R4 miss after reset", 0, 0, 0);
    @(negedge clk);
    judge("R2 idle after response", 0, 0, 0, 0);
  endtask

  task automatic t_basic();
    fill(vpn(15'd3, 5'd2), 20'hABCDE, 2'd1);
    look(vpn(15'd3, 5'd2), 12'h123, 2'd0, "R1 hit address", 1, 0, 32'hABCDE123);
    look(vpn(15'd3, 5'd2), 12'hFFF, 2'd1, "R1 offset all ones", 1, 0, 32'hABCDEFFF);
    look(vpn(15'd4, 5'd2), 12'h123, 2'd0, "R4 other tag same set", 0, 0, 0);
    look(vpn(15'd3, 5'd3), 12'h123, 2'd0, "R4 same tag other set", 0, 0, 0);
    fill(vpn(15'd3, 5'd2), 20'h11111, 2'd1);
    look(vpn(15'd3, 5'd2), 12'h010, 2'd0, "R6 refill overwrites", 1, 0, 32'h11111010);
    fill(vpn(15'd4, 5'd2), 20'h22222, 2'd1);
    fill(vpn(15'd5, 5'd2), 20'h33333, 2'd1);
    fill(vpn(15'd6, 5'd2), 20'h44444, 2'd1);
    look(vpn(15'd3, 5'd2), 12'h0, 2'd0, "R6 set full, first kept", 1, 0, 32'h11111000);
    look(vpn(15'd4, 5'd2), 12'h0, 2'd0, "R6 second way", 1, 0, 32'h22222000);
    look(vpn(15'd5, 5'd2), 12'h0, 2'd0, "R6 third way", 1, 0, 32'h33333000);
    look(vpn(15'd6, 5'd2), 12'h0, 2'd0, "R6 fourth way", 1, 0, 32'h44444000);
  endtask

  task automatic t_rights();
    fill(vpn(15'd1, 5'd3), 20'h00A00, 2'd0);
    fill(vpn(15'd1, 5'd4), 20'h00B00, 2'd1);
    fill(vpn(15'd1, 5'd5), 20'h00C00, 2'd2);
    fill(vpn(15'd1, 5'd6), 20'h00D00, 2'd3);
    look(vpn(15'd1, 5'd3), 12'h004, 2'd0, "R3 read-only read", 1, 0, 32'h00A00004);
    look(vpn(15'd1, 5'd3), 12'h004, 2'd1, "R5 read-only write", 0, 1, 0);
    look(vpn(15'd1, 5'd3), 12'h004, 2'd2, "R5 read-only exec", 0, 1, 0);
    look(vpn(15'd1, 5'd4), 12'h008, 2'd0, "R3 rw read", 1, 0, 32'h00B00008);
    look(vpn(15'd1, 5'd4), 12'h008, 2'd1, "R3 rw write", 1, 0, 32'h00B00008);
    look(vpn(15'd1, 5'd4), 12'h008, 2'd2, "R5 rw exec", 0, 1, 0);
    look(vpn(15'd1, 5'd5), 12'h00C, 2'd2, "R3 exec-only exec", 1, 0, 32'h00C0000C);
    look(vpn(15'd1, 5'd5), 12'h00C, 2'd0, "R5 exec-only read", 0, 1, 0);
    look(vpn(15'd1, 5'd5), 12'h00C, 2'd1, "R5 exec-only write", 0, 1, 0);
    look(vpn(15'd1, 5'd6), 12'h0, 2'd0, "R3 no-access read", 0, 1, 0);
    look(vpn(15'd1, 5'd4), 12'h0, 2'd3, "R3 kind 3 never allowed", 0, 1, 0);
  endtask

  task automatic t_plru();
    fill(vpn(15'd1, 5'd7), 20'h0000A, 2'd1);
    fill(vpn(15'd2, 5'd7), 20'h0000B, 2'd1);
    fill(vpn(15'd3, 5'd7), 20'h0000C, 2'd1);
    fill(vpn(15'd4, 5'd7), 20'h0000D, 2'd1);
    fill(vpn(15'd5, 5'd7), 20'h0000E, 2'd1);
    look(vpn(15'd1, 5'd7), 12'h0, 2'd0, "R9 way 0 evicted first", 0, 0, 0);
    look(vpn(15'd2, 5'd7), 12'h0, 2'd0, "R9 way 1 kept", 1, 0, 32'h0000B000);
    fill(vpn(15'd6, 5'd7), 20'h0000F, 2'd1);
    look(vpn(15'd3, 5'd7), 12'h0, 2'd0, "R9 way 2 evicted after hits", 0, 0, 0);
    look(vpn(15'd2, 5'd7), 12'h0, 2'd0, "R9 B kept", 1, 0, 32'h0000B000);
    look(vpn(15'd4, 5'd7), 12'h0, 2'd0, "R9 D kept", 1, 0, 32'h0000D000);
    look(vpn(15'd5, 5'd7), 12'h0, 2'd0, "R9 E kept", 1, 0, 32'h0000E000);
    look(vpn(15'd6, 5'd7), 12'h0, 2'd0, "R9 F placed", 1, 0, 32'h0000F000);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    lk_valid = 1; lk_vaddr = {vpn(15'd7, 5'd8), 12'h0}; lk_kind = 2'd0;
    fill_valid = 1; fill_vpn = vpn(15'd7, 5'd8); fill_pfn = 20'h77777; fill_rights = 2'd0;
    @(negedge clk); lk_valid = 0; fill_valid = 0;
    judge("R11 lookup ignores same-cycle fill", 1, 0, 0, 0);
    look(vpn(15'd7, 5'd8), 12'h0, 2'd0, "R11 fill visible next", 1, 0, 32'h77777000);
  endtask

  task automatic t_snoop();
    fill(vpn(15'd1, 5'd9), 20'h09001, 2'd1);
    fill(vpn(15'd2, 5'd9), 20'h09002, 2'd1);
    snoop(vpn(15'd1, 5'd9));
    look(vpn(15'd1, 5'd9), 12'h0, 2'd0, "R8 snooped page gone", 0, 0, 0);
    look(vpn(15'd2, 5'd9), 12'h0, 2'd0, "R8 neighbour kept", 1, 0, 32'h09002000);
    snoop(vpn(15'd3, 5'd9));
    look(vpn(15'd2, 5'd9), 12'h0, 2'd0, "R8 absent snoop no effect", 1, 0, 32'h09002000);
  endtask

  task automatic t_flush();
    look(vpn(15'd3, 5'd2), 12'h0, 2'd0, "R7 present before flush", 1, 0, 32'h11111000);
    do_flush();
    look(vpn(15'd3, 5'd2), 12'h0, 2'd0, "R7 set 2 flushed", 0, 0, 0);
    look(vpn(15'd1, 5'd4), 12'h0, 2'd0, "R7 set 4 flushed", 0, 0, 0);
    look(vpn(15'd2, 5'd9), 12'h0, 2'd0, "R7 set 9 flushed", 0, 0, 0);
  endtask

  task automatic t_flush_fill();
    fill(vpn(15'd1, 5'd10), 20'h0A001, 2'd1);
    @(negedge clk);
    flush = 1; fill_valid = 1; fill_vpn = vpn(15'd2, 5'd10); fill_pfn = 20'h0A002; fill_rights = 2'd1;
    @(negedge clk); flush = 0; fill_valid = 0;
    look(vpn(15'd2, 5'd10), 12'h0, 2'd0, "R10 flush beats fill", 0, 0, 0);
    look(vpn(15'd1, 5'd10), 12'h0, 2'd0, "R10 older entry flushed", 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog (all requirements): got hung run, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_rights();
    t_plru();
    t_same_cycle();
    t_snoop();
    t_flush();
    t_flush_fill();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule